// File: doc/BRIEF.md
# Fan Duty Slew Limiter

This block sits between an automatic fan-speed calculator and the PWM waveform generator. The calculator can produce sudden jumps in the requested duty, for example after a short temperature spike. When slew limiting is on, the block moves the applied duty toward the requested value by one count per programmed interval, so the fan speed changes gradually and makes less noise. When slew limiting is off, the applied duty follows the request on the next clock.

The interval per one-count step is given as a number of 1 ms timebase ticks. A 3-bit rate code selects it from a fixed, non-linear table. The block also holds an 8-bit minimum-duty register. A sticky lock makes this register read-only until reset. The block does not apply the minimum duty itself. It only presents the register value to the logic downstream.

Top module: `pwm_slew_limiter`

## Requirements
- R1: After a synchronous reset, `applied_duty` is 00h, `min_duty` is 80h and `locked` is 0.
- R2: While `slew_en` is 0, `applied_duty` equals the `target_duty` sampled at the previous clock edge.
- R3: While `slew_en` is 1, `applied_duty` changes only on a clock edge where `tick_1ms` is high, and then by exactly one count.
- R4: The tick interval per step is selected by the rate code: 206 ticks for code 0 (000b), 104 for code 1, 69 for code 2 and 41 for code 3. The first step comes on the N-th tick after the interval restarts.
- R5: The interval is 26 ticks for code 4 (100b), 18 for code 5, 10 for code 6 and 5 for code 7 (111b).
- R6: Each step moves toward the current target, upward or downward. If the target reverses in the middle of a ramp, the next step goes toward the new target from the present applied value, which is not reset.
- R7: While `applied_duty` equals `target_duty`, no step is taken and the interval count stays at zero. A later target change therefore waits a full interval before its first step.
- R8: A change of `rate_code` restarts the interval count. The next step then comes a full new interval after the change.
- R9: While the register is unlocked, `min_wr_en` loads `min_wr_data` into `min_duty` at the next edge. A write in the same cycle as `lock_req` is still accepted.
- R10: After `lock_req` has been seen, `locked` stays 1 until reset and writes to `min_duty` have no effect.
- R11: With code 7, a full sweep of `applied_duty` from 00h to FFh takes 1275 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1ms | input | 1 | One-cycle pulse each millisecond |
| slew_en | input | 1 | 1 = ramp one count per interval, 0 = follow the target directly |
| rate_code | input | 3 | Selects the step interval |
| target_duty | input | 8 | Requested duty from the fan-control calculator |
| min_wr_en | input | 1 | Write strobe for the minimum-duty register |
| min_wr_data | input | 8 | Write data for the minimum-duty register |
| lock_req | input | 1 | Sets the sticky lock |
| applied_duty | output | 8 | Duty sent to the PWM generator |
| min_duty | output | 8 | Minimum-duty register value |
| locked | output | 1 | Lock state |

## Verification
The hardest state to reach from the ports is an interval count that has been partly used and is then disturbed. This happens when the target reverses right after a step, or when the rate code changes while the count is deep into a long interval. To reach it, the bench first settles the applied duty with bypass mode. It then counts ticks one at a time: 100 ticks into a 206-tick interval it switches the code, and after two steps of a ramp it reverses the target. After each disturbance it measures exactly how many ticks pass before the next step and compares that with the expected interval.

// File: rtl/fan_slew_pkg.sv
package fan_slew_pkg;

    localparam int DUTY_W = 8;
    localparam int CODE_W = 3;
    localparam int TCNT_W = 8;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [TCNT_W-1:0] tcnt_t;

    typedef enum logic [CODE_W-1:0] {
        RATE_206 = 3'd0,
        RATE_104 = 3'd1,
        RATE_69  = 3'd2,
        RATE_41  = 3'd3,
        RATE_26  = 3'd4,
        RATE_18  = 3'd5,
        RATE_10  = 3'd6,
        RATE_5   = 3'd7
    } rate_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    // Number of millisecond ticks that must pass for each one-count step.
    function automatic tcnt_t rate_ticks(input rate_e code);
        case (code)
            RATE_206: rate_ticks = 8'd206;
            RATE_104: rate_ticks = 8'd104;
            RATE_69:  rate_ticks = 8'd69;
            RATE_41:  rate_ticks = 8'd41;
            RATE_26:  rate_ticks = 8'd26;
            RATE_18:  rate_ticks = 8'd18;
            RATE_10:  rate_ticks = 8'd10;
            default:  rate_ticks = 8'd5;
        endcase
    endfunction

    function automatic dir_e pick_dir(input duty_t cur, input duty_t tgt);
        if (tgt > cur)      pick_dir = DIR_UP;
        else if (tgt < cur) pick_dir = DIR_DOWN;
        else                pick_dir = DIR_HOLD;
    endfunction

endpackage

// File: rtl/slew_interval_timer.sv
module slew_interval_timer
    import fan_slew_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          active,
    input  rate_e         code,
    output logic          step_go
);
    tcnt_t cnt_q;
    rate_e code_q;
    tcnt_t limit;
    logic  code_chg;

    assign limit    = rate_ticks(code);
    assign code_chg = (code != code_q);
    assign step_go  = active && !code_chg && tick && (cnt_q == limit - 8'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            code_q <= RATE_206;
        end else begin
            code_q <= code;
            if (!active || code_chg) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == limit - 8'd1) cnt_q <= '0;
                else                       cnt_q <= cnt_q + 8'd1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < rate_ticks(code_q)); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |=> cnt_q == '0); // R7
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        step_go |-> tick); // R3
endmodule

// File: rtl/duty_stepper.sv
module duty_stepper
    import fan_slew_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  slew_en,
    input  duty_t target,
    input  logic  step_go,
    output logic  active,
    output duty_t cur
);
    dir_e  dir;

    assign dir    = pick_dir(cur, target);
    assign active = slew_en && (dir != DIR_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (!slew_en) begin
            cur <= target;
        end else if (step_go) begin
            case (dir)
                DIR_UP:   cur <= cur + 8'd1;
                DIR_DOWN: cur <= cur - 8'd1;
                default:  cur <= cur;
            endcase
        end
    end

    AST_BYPASS_TRACK: assert property (@(posedge clk) disable iff (rst)
        !slew_en |=> cur == $past(target)); // R2
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (slew_en && !step_go) |=> $stable(cur)); // R3
    AST_ONE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (slew_en && step_go) |=> (cur == 8'($past(cur) + 8'd1)) || (cur == 8'($past(cur) - 8'd1))); // R3
    AST_TOWARD: assert property (@(posedge clk) disable iff (rst)
        (slew_en && step_go && (target > cur)) |=> cur > $past(cur)); // R6
endmodule

// File: rtl/min_duty_reg.sv
module min_duty_reg
    import fan_slew_pkg::*;
#(
    parameter duty_t RESET_VAL = 8'h80
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  duty_t wr_data,
    input  logic  lock_req,
    output duty_t value,
    output logic  locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= RESET_VAL;
            locked <= 1'b0;
        end else begin
            if (lock_req) locked <= 1'b1;
            if (wr_en && !locked) value <= wr_data;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R10
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(value)); // R10
endmodule

// File: rtl/pwm_slew_limiter.sv
module pwm_slew_limiter
    import fan_slew_pkg::*;
#(
    parameter logic [7:0] MIN_RESET = 8'h80
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1ms,
    input  logic       slew_en,
    input  logic [2:0] rate_code,
    input  logic [7:0] target_duty,
    input  logic       min_wr_en,
    input  logic [7:0] min_wr_data,
    input  logic       lock_req,
    output logic [7:0] applied_duty,
    output logic [7:0] min_duty,
    output logic       locked
);
    logic  step_go;
    logic  active;
    rate_e code;

    assign code = rate_e'(rate_code);

    slew_interval_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .active  (active),
        .code    (code),
        .step_go (step_go)
    );

    duty_stepper u_step (
        .clk     (clk),
        .rst     (rst),
        .slew_en (slew_en),
        .target  (target_duty),
        .step_go (step_go),
        .active  (active),
        .cur     (applied_duty)
    );

    min_duty_reg #(.RESET_VAL(MIN_RESET)) u_min (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (min_wr_en),
        .wr_data  (min_wr_data),
        .lock_req (lock_req),
        .value    (min_duty),
        .locked   (locked)
    );
endmodule

// File: tb/tb_pwm_slew_limiter.sv
module tb_pwm_slew_limiter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_1ms;
    logic       slew_en;
    logic [2:0] rate_code;
    logic [7:0] target_duty;
    logic       min_wr_en;
    logic [7:0] min_wr_data;
    logic       lock_req;
    logic [7:0] applied_duty;
    logic [7:0] min_duty;
    logic       locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_slew_limiter dut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .slew_en(slew_en),
        .rate_code(rate_code), .target_duty(target_duty),
        .min_wr_en(min_wr_en), .min_wr_data(min_wr_data), .lock_req(lock_req),
        .applied_duty(applied_duty), .min_duty(min_duty), .locked(locked)
    );

    function automatic int interval_of(input int code);
        case (code)
            0: return 206; 1: return 104; 2: return 69; 3: return 41;
            4: return 26;  5: return 18;  6: return 10; default: return 5;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        tick_1ms = t;
        @(posedge clk);
        @(negedge clk);
        tick_1ms = 1'b0;
    endtask

    // Bypass to a known value, then enable ramping with the given code and target.
    task automatic setup(input int start, input int code, input int tgt);
        slew_en = 1'b0; target_duty = 8'(start); cyc(1'b0);
        slew_en = 1'b1; rate_code = 3'(code); target_duty = 8'(tgt); cyc(1'b0);
    endtask

    // Ticks every cycle until applied_duty moves; returns tick count.
    task automatic ticks_to_step(output int n);
        logic [7:0] s;
        s = applied_duty;
        n = 0;
        while (applied_duty == s && n < 400) begin
            cyc(1'b1);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; tick_1ms = 0; slew_en = 0; rate_code = 0; target_duty = 0;
        min_wr_en = 0; min_wr_data = 0; lock_req = 0;
        @(negedge clk); cyc(1'b0); cyc(1'b0);
        rst = 1'b0;
        // R1
        chk("R1 applied", applied_duty, 0);
        chk("R1 min", min_duty, 8'h80);
        chk("R1 lock", locked, 0);

        // R2 bypass sweep
        for (int v = 0; v < 256; v += 17) begin
            target_duty = 8'(v);
            cyc(1'b0);
            chk("R2 bypass", applied_duty, v);
        end

        // R3 no change without tick while enabled
        setup(10, 7, 50);
        for (int i = 0; i < 20; i++) cyc(1'b0);
        chk("R3 no tick hold", applied_duty, 10);

        // R4 / R5 every code, both directions
        for (int c = 0; c < 8; c++) begin
            setup(100, c, 110);
            ticks_to_step(n);
            chk(c < 4 ? "R4 up interval" : "R5 up interval", n, interval_of(c));
            chk("R3 up one count", applied_duty, 101);
            setup(100, c, 90);
            ticks_to_step(n);
            chk(c < 4 ? "R4 down interval" : "R5 down interval", n, interval_of(c));
            chk("R6 down one count", applied_duty, 99);
        end

        // R6 reversal mid-ramp
        setup(40, 7, 60);
        for (int i = 0; i < 10; i++) cyc(1'b1);
        chk("R6 ramp progress", applied_duty, 42);
        target_duty = 8'd20;
        ticks_to_step(n);
        chk("R6 reversal interval", n, 5);
        chk("R6 reversal value", applied_duty, 41);

        // R7 idle at target then new target waits full interval
        setup(70, 6, 72);
        for (int i = 0; i < 20; i++) cyc(1'b1);
        chk("R7 reached", applied_duty, 72);
        for (int i = 0; i < 7; i++) cyc(1'b1);
        chk("R7 holds", applied_duty, 72);
        target_duty = 8'd80; cyc(1'b0);
        ticks_to_step(n);
        chk("R7 full interval", n, 10);

        // R8 code change restarts count
        setup(30, 0, 60);
        for (int i = 0; i < 100; i++) cyc(1'b1);
        chk("R8 no early step", applied_duty, 30);
        rate_code = 3'd7; cyc(1'b0);
        ticks_to_step(n);
        chk("R8 restart interval", n, 5);

        // R11 full sweep
        setup(0, 7, 255);
        n = 0;
        while (applied_duty != 8'd255 && n < 2000) begin
            cyc(1'b1);
            n++;
        end
        chk("R11 sweep ticks", n, 1275);

        // R9 write unlocked
        min_wr_en = 1; min_wr_data = 8'h33; cyc(1'b0); min_wr_en = 0;
        chk("R9 write", min_duty, 8'h33);
        min_wr_en = 1; min_wr_data = 8'h44; lock_req = 1; cyc(1'b0);
        min_wr_en = 0; lock_req = 0;
        chk("R9 write with lock", min_duty, 8'h44);
        chk("R10 locked", locked, 1);
        // R10 writes ignored, lock sticky
        min_wr_en = 1; min_wr_data = 8'h99; cyc(1'b0);
        min_wr_data = 8'h00; cyc(1'b0); min_wr_en = 0;
        chk("R10 write ignored", min_duty, 8'h44);
        for (int i = 0; i < 5; i++) cyc(1'b0);
        chk("R10 sticky", locked, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule